// File: doc/BRIEF.md
# Fetch Thread Selector

This block decides, once per fetch cycle, which hardware thread of a multithreaded core may fetch. A neighbouring status block supplies one status code per thread. The selector also takes a per-thread active mask, a two-bit policy select, and two per-thread occupancy counts, one for the issue queue and one for the load/store queue. It returns a thread index with a valid flag for each fetch slot of the cycle.

Three arbitration schemes are available: fixed thread 0, round-robin, and least-occupancy. For round-robin, the selector keeps an ordered list of thread indices in flops. Each grant moves the granted thread to the tail of that list. When the core has more than one fetch slot per cycle, the slots are resolved in sequence inside the same cycle. Each slot sees the list as left by the slots before it.

A build with a single thread skips arbitration entirely. The block decides nothing about caches, instruction bytes or status transitions.

Top module: `fetch_thread_pick`

## Requirements
- R1: Only three status codes make a thread eligible: 0 (idle), 1 (running) and 2 (miss complete). Codes 3 to 7 (blocked, squashing, miss outstanding, trap pending, quiesce) never lead to a grant under round-robin or occupancy policies.
- R2: Under round-robin and occupancy policies, a thread whose active-mask bit is 0 is never granted.
- R3: Policy code 1 selects round-robin. The order list is scanned from head to tail, and the first eligible thread is granted. That thread is then removed from its position and placed at the tail.
- R4: Reset loads the order list as 0, 1, ..., N-1, with thread 0 at the head.
- R5: When no thread is eligible, a slot reports valid = 0.
- R6: Policy code 0 (fixed thread) grants thread 0 with valid = 1 in every slot. This holds whatever the status or active mask, provided more than one thread exists.
- R7: With a single thread configured, the policy input is ignored. Every slot grants thread 0 exactly when that thread is eligible and active.
- R8: Policy codes 2 and 3 grant the eligible active thread with the smallest occupancy. Code 2 uses the issue-queue counts and code 3 uses the load/store-queue counts. Ties go to the lower index. Thread t occupies bits [t*W +: W] of each count bus, and each thread's status likewise sits at [t*3 +: 3].
- R9: Slots are resolved in order within one cycle. Slot k sees the order list after the rotations made by slots 0..k-1. Once a slot has no grant, every later slot of that cycle has none either.
- R10: The order list changes only under policy 1. Under any other policy it holds its contents, and round-robin later resumes from where it left off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status_i | input | NTHREADS*STAT_W | Per-thread fetch status code, thread 0 in the low bits |
| active_i | input | NTHREADS | Per-thread active mask |
| policy_i | input | 2 | 0 fixed, 1 round-robin, 2 issue-queue count, 3 load/store-queue count |
| iq_occ_i | input | NTHREADS*OCC_W | Per-thread issue-queue occupancy |
| lsq_occ_i | input | NTHREADS*OCC_W | Per-thread load/store-queue occupancy |
| grant_vld_o | output | NSLOTS | Per-slot grant valid |
| grant_tid_o | output | NSLOTS*TID_W | Per-slot granted thread index, slot 0 in the low bits |

## Verification
The bench walks a sequence of round-robin cycles whose expected grants depend on the list history. An implementation that does not move the winner to the tail, or that rotates only once for both slots, grants the wrong thread in the second slot. Ineligible heads and an active mask with only one thread set expose a scan that trusts status alone. Such a design would hand a grant to a blocked or parked thread.

Equal occupancy counts check that ties go to the lower index. Switching between the two count buses checks that code 3 does not read the issue-queue counts. A round-robin run placed after fixed-thread and occupancy cycles shows whether the list drifted while another policy was selected. A mid-run reset shows whether the list really returns to ascending order. A single-thread instance with a blocked thread and policy 0 shows whether the bypass wrongly honours the fixed-thread rule.

// File: rtl/fetch_thread_pick.sv
module fetch_thread_pick #(
  parameter int NTHREADS = 4,
  parameter int NSLOTS   = 2,
  parameter int OCC_W    = 6,
  parameter int STAT_W   = 3,
  localparam int TID_W   = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NTHREADS*STAT_W-1:0] status_i,
  input  logic [NTHREADS-1:0]        active_i,
  input  logic [1:0]                 policy_i,
  input  logic [NTHREADS*OCC_W-1:0]  iq_occ_i,
  input  logic [NTHREADS*OCC_W-1:0]  lsq_occ_i,
  output logic [NSLOTS-1:0]          grant_vld_o,
  output logic [NSLOTS*TID_W-1:0]    grant_tid_o
);

  localparam logic [1:0] POL_FIXED = 2'd0;
  localparam logic [1:0] POL_RR    = 2'd1;
  localparam logic [1:0] POL_LSQ   = 2'd3;

  localparam logic [STAT_W-1:0] ST_IDLE  = STAT_W'(0);
  localparam logic [STAT_W-1:0] ST_RUN   = STAT_W'(1);
  localparam logic [STAT_W-1:0] ST_MDONE = STAT_W'(2);

  logic [NTHREADS-1:0] elig;

  always_comb begin
    for (int t = 0; t < NTHREADS; t++) begin
      elig[t] = active_i[t] &&
                (status_i[t*STAT_W +: STAT_W] == ST_IDLE ||
                 status_i[t*STAT_W +: STAT_W] == ST_RUN  ||
                 status_i[t*STAT_W +: STAT_W] == ST_MDONE);
    end
  end

  function automatic logic ready_at(input logic [NTHREADS*STAT_W-1:0] st,
                                    input logic [NTHREADS-1:0] act,
                                    input int t);
    logic [STAT_W-1:0] c;
    c = st[t*STAT_W +: STAT_W];
    return act[t] && (c < STAT_W'(3));
  endfunction

  function automatic logic any_ready(input logic [NTHREADS*STAT_W-1:0] st,
                                     input logic [NTHREADS-1:0] act);
    logic r;
    r = 1'b0;
    for (int t = 0; t < NTHREADS; t++) r = r | ready_at(st, act, t);
    return r;
  endfunction

  generate
    if (NTHREADS == 1) begin : g_solo
      assign grant_vld_o = {NSLOTS{elig[0]}};
      assign grant_tid_o = '0;

      always_ff @(posedge clk) begin
        if (rst_n) begin
          assert_solo_bypass_R7: assert (grant_vld_o[0] == (active_i[0] && status_i < STAT_W'(3)))
            else $error("single-thread bypass mismatch");
        end
      end
    end else begin : g_multi
      typedef logic [NTHREADS-1:0][TID_W-1:0] order_t;

      order_t                     order_q, order_d;
      logic [NSLOTS-1:0]          rr_vld;
      logic [NSLOTS-1:0][TID_W-1:0] rr_tid;
      logic                       occ_hit;
      logic [TID_W-1:0]           occ_tid;

      always_comb begin
        logic [OCC_W-1:0] best, cur_occ;
        occ_hit = 1'b0;
        occ_tid = '0;
        best    = '0;
        for (int t = 0; t < NTHREADS; t++) begin
          cur_occ = (policy_i == POL_LSQ) ? lsq_occ_i[t*OCC_W +: OCC_W]
                                          : iq_occ_i[t*OCC_W +: OCC_W];
          if (elig[t] && (!occ_hit || cur_occ < best)) begin
            occ_hit = 1'b1;
            best    = cur_occ;
            occ_tid = TID_W'(t);
          end
        end
      end

      always_comb begin
        order_t           cur, nxt;
        logic             hit;
        logic [TID_W-1:0] who;
        int               pos;
        cur = order_q;
        for (int s = 0; s < NSLOTS; s++) begin
          hit = 1'b0;
          who = '0;
          pos = 0;
          for (int i = 0; i < NTHREADS; i++) begin
            if (!hit && elig[cur[i]]) begin
              hit = 1'b1;
              who = cur[i];
              pos = i;
            end
          end
          nxt = cur;
          if (hit) begin
            for (int i = 0; i < NTHREADS; i++) begin
              if (i >= pos) begin
                if (i == NTHREADS - 1) nxt[i] = who;
                else                   nxt[i] = cur[(i + 1 < NTHREADS) ? i + 1 : i];
              end
            end
          end
          rr_vld[s] = hit;
          rr_tid[s] = who;
          cur       = nxt;
        end
        order_d = cur;
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < NTHREADS; i++) order_q[i] <= TID_W'(i);
        end else if (policy_i == POL_RR) begin
          order_q <= order_d;
        end
      end

      always_comb begin
        logic alive, v;
        alive = 1'b1;
        for (int s = 0; s < NSLOTS; s++) begin
          unique case (policy_i)
            POL_FIXED: begin v = 1'b1;      grant_tid_o[s*TID_W +: TID_W] = '0;        end
            POL_RR:    begin v = rr_vld[s]; grant_tid_o[s*TID_W +: TID_W] = rr_tid[s]; end
            default:   begin v = occ_hit;   grant_tid_o[s*TID_W +: TID_W] = occ_tid;   end
          endcase
          v              = v & alive;
          grant_vld_o[s] = v;
          alive          = v;
        end
      end

      for (genvar s = 0; s < NSLOTS; s++) begin : g_chk
        assert_grant_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
          (grant_vld_o[s] && policy_i != POL_FIXED) |->
            ready_at(status_i, active_i, int'(grant_tid_o[s*TID_W +: TID_W])))
          else $error("slot granted a thread that cannot fetch");

        assert_fixed_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
          (policy_i == POL_FIXED) |-> (grant_vld_o[s] && grant_tid_o[s*TID_W +: TID_W] == '0))
          else $error("fixed policy did not grant thread 0");

        assert_none_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
          (policy_i != POL_FIXED && !any_ready(status_i, active_i)) |-> !grant_vld_o[s])
          else $error("grant with no ready thread");

        if (s > 0) begin : g_chain
          assert_slot_chain_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !grant_vld_o[s-1] |-> !grant_vld_o[s])
            else $error("later slot granted after an empty slot");
        end
      end

      assert_hold_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i != POL_RR) |=> $stable(order_q))
        else $error("order list moved outside round-robin");

      assert_tail_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i == POL_RR && grant_vld_o[NSLOTS-1]) |=>
          (order_q[NTHREADS-1] == $past(grant_tid_o[(NSLOTS-1)*TID_W +: TID_W])))
        else $error("last winner not at list tail");
    end
  endgenerate

endmodule

// File: tb/sim_fetch_thread_pick.sv
module sim_fetch_thread_pick;
  localparam int CLK_P = 10;
  localparam int N = 4, S = 2, OW = 6, SW = 3, TW = 2;

  typedef struct packed {
    logic [1:0]      pol;
    logic [N*SW-1:0] st;
    logic [N-1:0]    act;
    logic [N*OW-1:0] iq;
    logic [N*OW-1:0] lsq;
    logic [1:0]      vld;
    logic [S*TW-1:0] tid;
  } vec_t;

  localparam int NV = 13;
  // Each vector follows the previous one without reset; round-robin expectations
  // assume the list history of the vectors above it.
  localparam vec_t VECS [NV] = '{
    '{2'd1, 12'o1111, 4'hF, 24'd0, 24'd0, 2'b11, {2'd1, 2'd0}},                                   // R4 R3 R9 list 0123 -> 2301
    '{2'd1, 12'o1311, 4'hF, 24'd0, 24'd0, 2'b11, {2'd0, 2'd3}},                                   // R1 R3 -> 2130
    '{2'd1, 12'o3313, 4'hF, 24'd0, 24'd0, 2'b11, {2'd1, 2'd1}},                                   // R1 R9 -> 2301
    '{2'd1, 12'o1111, 4'h1, 24'd0, 24'd0, 2'b11, {2'd0, 2'd0}},                                   // R2 -> 2310
    '{2'd1, 12'o5674, 4'hF, 24'd0, 24'd0, 2'b00, {2'd0, 2'd0}},                                   // R5 R1
    '{2'd0, 12'o3333, 4'h0, 24'd0, 24'd0, 2'b11, {2'd0, 2'd0}},                                   // R6
    '{2'd2, 12'o0000, 4'hF, {6'd4, 6'd7, 6'd4, 6'd9}, {6'd0, 6'd0, 6'd0, 6'd1}, 2'b11, {2'd1, 2'd1}}, // R8 tie
    '{2'd3, 12'o0000, 4'hF, {6'd4, 6'd7, 6'd4, 6'd9}, {6'd8, 6'd2, 6'd3, 6'd5}, 2'b11, {2'd2, 2'd2}}, // R8 lsq bus
    '{2'd2, 12'o2232, 4'hF, {6'd9, 6'd7, 6'd0, 6'd9}, 24'd0, 2'b11, {2'd2, 2'd2}},                   // R8 R1
    '{2'd2, 12'o2232, 4'hB, {6'd9, 6'd7, 6'd0, 6'd9}, 24'd0, 2'b11, {2'd0, 2'd0}},                   // R2 R8
    '{2'd3, 12'o3333, 4'hF, 24'd0, 24'd0, 2'b00, {2'd0, 2'd0}},                                   // R5 R9
    '{2'd1, 12'o1111, 4'hF, 24'd0, 24'd0, 2'b11, {2'd3, 2'd2}},                                   // R10 list held at 2310
    '{2'd1, 12'o1111, 4'hF, 24'd0, 24'd0, 2'b11, {2'd0, 2'd1}}                                    // R3 -> 2310
  };

  function automatic string vec_tag(input int k);
    case (k)
      0: return "R4/R3/R9";  1: return "R1/R3";  2: return "R1/R9";
      3: return "R2";        4: return "R5";     5: return "R6";
      6: return "R8-tie";    7: return "R8-lsq"; 8: return "R8/R1";
      9: return "R2/R8";     10: return "R5/R9"; 11: return "R10";
      default: return "R3";
    endcase
  endfunction

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N*SW-1:0] status;
  logic [N-1:0]    active;
  logic [1:0]      policy;
  logic [N*OW-1:0] iq_occ, lsq_occ;
  logic [S-1:0]    gv;
  logic [S*TW-1:0] gt;

  logic [SW-1:0]   s1_status;
  logic            s1_active;
  logic [S-1:0]    s1_gv;
  logic [S-1:0]    s1_gt;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fetch_thread_pick #(.NTHREADS(N), .NSLOTS(S), .OCC_W(OW), .STAT_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .status_i(status), .active_i(active), .policy_i(policy),
    .iq_occ_i(iq_occ), .lsq_occ_i(lsq_occ), .grant_vld_o(gv), .grant_tid_o(gt));

  fetch_thread_pick #(.NTHREADS(1), .NSLOTS(S), .OCC_W(OW), .STAT_W(SW)) u1 (
    .clk(clk), .rst_n(rst_n), .status_i(s1_status), .active_i(s1_active), .policy_i(policy),
    .iq_occ_i(iq_occ[OW-1:0]), .lsq_occ_i(lsq_occ[OW-1:0]), .grant_vld_o(s1_gv), .grant_tid_o(s1_gt));

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    status = '0; active = '0; policy = 2'd1; iq_occ = '0; lsq_occ = '0;
    s1_status = '0; s1_active = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      policy  = VECS[k].pol;
      status  = VECS[k].st;
      active  = VECS[k].act;
      iq_occ  = VECS[k].iq;
      lsq_occ = VECS[k].lsq;
      #1;
      check(vec_tag(k), {2'b00, gv, gt}, {2'b00, VECS[k].vld, VECS[k].tid});
      @(negedge clk);
    end

    // R4: reset mid-run restores ascending order (list was 2310)
    rst_n = 1'b0;
    @(negedge clk);
    rst_n  = 1'b1;
    policy = 2'd1; status = 12'o1111; active = 4'hF;
    #1;
    check("R4 reset order", {2'b00, gv, gt}, {2'b00, 2'b11, 2'd1, 2'd0});
    @(negedge clk);

    // R3: only thread 3 ready; list 2301 -> winner 3 twice
    status = 12'o1333;
    #1;
    check("R3 single ready tail", {2'b00, gv, gt}, {2'b00, 2'b11, 2'd3, 2'd3});
    @(negedge clk);

    // R7: single-thread build ignores policy
    policy = 2'd0; s1_status = 3'd3; s1_active = 1'b1;
    #1;
    check("R7 blocked under fixed", {4'h0, s1_gv, s1_gt}, {4'h0, 2'b00, 2'b00});
    @(negedge clk);
    s1_status = 3'd2; policy = 2'd2;
    #1;
    check("R7 ready", {4'h0, s1_gv, s1_gt}, {4'h0, 2'b11, 2'b00});
    @(negedge clk);
    s1_active = 1'b0; policy = 2'd1;
    #1;
    check("R7 inactive", {4'h0, s1_gv, s1_gt}, {4'h0, 2'b00, 2'b00});
    @(negedge clk);

    done = 1'b1;
    finish_run();
  end
endmodule